// File: doc/BRIEF.md
# Register Region Decoder with Access Validation

This block stands between a bus master and a bank of registers. Every request carries a byte offset, a size code, a read/write flag and write data. Within the request cycle the decoder finds which entry of a fixed, sorted region table holds the offset. It then checks that the access is legal for that region, and it either raises a read or write strobe toward the bank or gives a neutral response. Illegal and unmapped accesses never raise a bus error. Reads of them return zero and writes to them are dropped.

Each region has a start offset, a length, a mask of permitted access sizes, a bits-per-interrupt value and a kind. For a region indexed by interrupt, the interrupt number is derived from the offset and must be below the number of implemented interrupts. The kind can make a region return zeros, return all ones, or ignore writes while still forwarding reads. Bus data is little-endian. The bank works in host order, so a parameter selects whether bytes are reversed within the access width.

Top module: `regdec_top`

## Requirements
- R1: An offset hits a region when start <= offset < start + length. The first table entry that matches is selected and reported on `regIdx`. Offsets in no region are unmapped. Default table (start, length, sizes, bits-per-interrupt, kind): 0: 0x000, 0x10, 4B, 0, plain; 1: 0x010, 0x10, 4B, 0, zero; 2: 0x080, 0x80, 4B/8B, 1, plain; 3: 0x100, 0x100, 1B/4B, 8, plain; 4: 0x200, 0x10, 4B, 0, ones; 5: 0x210, 0x10, 4B, 0, no-write.
- R2: The size code is `reqSize` (0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes). A 2-byte access is never legal.
- R3: An access is rejected when its size is not in the region's size mask.
- R4: An access is rejected unless the offset is a multiple of its byte count.
- R5: In a region with non-zero bits-per-interrupt B, the interrupt number is (offset - start) * 8 / B. It must be below NumPrivate + NumShared, which is 96 by default, or the access is rejected.
- R6: A region with bits-per-interrupt 0 performs no interrupt range check.
- R7: A rejected or unmapped read gives `rspValid` = 1 with `rspData` = 0 one cycle later. A rejected or unmapped write raises no strobe.
- R8: `regHit` is high only for a valid, legal access. `regRdStb` and `regWrStb` are high only with `regHit`, and never together. Every valid read gets `rspValid` in the next cycle and only then. `rspValid` is 0 after reset.
- R9: With host big-endian (default), host byte i equals bus byte n-1-i for an n-byte access, in both directions. Bytes above the access width are zero.
- R10: In a zero-kind region, a legal read returns 0 without a read strobe, and a write raises no strobe.
- R11: In a ones-kind region, a legal read returns all ones across the access width and zero above it, without a read strobe. A write raises no strobe.
- R12: In a no-write region, a legal read is forwarded, and a write raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqOffset | input | 12 | Byte offset of the access |
| reqSize | input | 2 | Size code (0:1B, 1:2B, 2:4B, 3:8B) |
| reqWData | input | 64 | Write data in bus (little-endian) order |
| regIdx | output | 3 | Index of the matching region |
| regHit | output | 1 | Access is valid and legal |
| regRdStb | output | 1 | Read forwarded to the bank |
| regWrStb | output | 1 | Write forwarded to the bank |
| regWData | output | 64 | Write data in host order |
| regRdData | input | 64 | Bank read data in host order, same cycle |
| rspValid | output | 1 | Read response valid |
| rspData | output | 64 | Read response in bus order |

## Verification
Two things share a cycle: the registered response of one read, and the decode and strobes of the next request. Back-to-back requests provoke this, including legal reads followed at once by rejected ones and the reverse. Each cycle's response is judged against the model's result from the previous cycle, while the strobes are judged against the current request. A single request can also fail several rules at once, for example a misaligned access at an out-of-range interrupt. Directed offsets at the last valid and first invalid interrupt, together with random traffic, show that any failing rule yields a zero response and no strobe.

// File: rtl/regdec_pkg.sv
package regdec_pkg;

  typedef enum logic [1:0] {
    KIND_PLAIN   = 2'd0,
    KIND_ZERO    = 2'd1,
    KIND_ONES    = 2'd2,
    KIND_NOWRITE = 2'd3
  } regionKind_e;

  typedef struct packed {
    logic       rdFwd;
    logic       wrFwd;
    logic       rdZero;
    logic       rdOnes;
    logic       rspLoad;
    logic [1:0] size;
  } ctlStrobes_t;

  function automatic int bpiShift(input int bpi);
    case (bpi)
      1:       return 0;
      2:       return 1;
      4:       return 2;
      8:       return 3;
      default: return 4;
    endcase
  endfunction

  // Keeps the low 2**size bytes, optionally reversing their order.
  function automatic logic [63:0] laneOrder(input logic [63:0] d,
                                            input logic [1:0] size,
                                            input logic rev);
    logic [63:0] o;
    int nb;
    nb = 1 << size;
    o = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < nb) begin
        if (rev) o[8*i +: 8] = d[8*(nb-1-i) +: 8];
        else     o[8*i +: 8] = d[8*i +: 8];
      end
    end
    return o;
  endfunction

  function automatic logic [63:0] sizeOnes(input logic [1:0] size);
    case (size)
      2'd0:    return 64'h0000_0000_0000_00FF;
      2'd1:    return 64'h0000_0000_0000_FFFF;
      2'd2:    return 64'h0000_0000_FFFF_FFFF;
      default: return 64'hFFFF_FFFF_FFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/regdec_ctrl.sv
module regdec_ctrl
  import regdec_pkg::*;
#(
  parameter int NumRegions = 6,
  parameter int OffW       = 12,
  parameter int NumPrivate = 32,
  parameter int NumShared  = 64,
  parameter logic [NumRegions*OffW-1:0] RegionStart = '0,
  parameter logic [NumRegions*OffW-1:0] RegionLen   = '0,
  parameter logic [NumRegions*3-1:0]    RegionMask  = '0,
  parameter logic [NumRegions*4-1:0]    RegionBpi   = '0,
  parameter logic [NumRegions*2-1:0]    RegionKind  = '0,
  localparam int IdxW = (NumRegions > 1) ? $clog2(NumRegions) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [OffW-1:0] reqOffset,
  input  logic [1:0]      reqSize,
  output logic            regHit,
  output logic [IdxW-1:0] regIdx,
  output ctlStrobes_t     strb
);

  localparam int IntW = OffW + 3;
  localparam logic [IntW-1:0] NumIrqV = IntW'(NumPrivate + NumShared);

  logic [NumRegions-1:0] inReg;
  logic [NumRegions-1:0] sizeOk;
  logic [NumRegions-1:0] rangeOk;
  logic [NumRegions-1:0] legal;
  logic                  alignOk;
  logic [IdxW-1:0]       matchIdx;
  logic                  matchAny;
  logic                  accOk;
  regionKind_e           selKind;

  always_comb begin
    case (reqSize)
      2'd0:    alignOk = 1'b1;
      2'd1:    alignOk = (reqOffset[0] == 1'b0);
      2'd2:    alignOk = (reqOffset[1:0] == 2'b00);
      default: alignOk = (reqOffset[2:0] == 3'b000);
    endcase
  end

  for (genvar r = 0; r < NumRegions; r++) begin : g_region
    localparam logic [OffW-1:0] StartV = RegionStart[r*OffW +: OffW];
    localparam logic [OffW-1:0] LenV   = RegionLen[r*OffW +: OffW];
    localparam logic [2:0]      MaskV  = RegionMask[r*3 +: 3];
    localparam int              Bpi    = int'(RegionBpi[r*4 +: 4]);
    localparam logic [OffW:0]   EndV   = {1'b0, StartV} + {1'b0, LenV};

    assign inReg[r] = (reqOffset >= StartV) && ({1'b0, reqOffset} < EndV);

    always_comb begin
      case (reqSize)
        2'd0:    sizeOk[r] = MaskV[0];
        2'd2:    sizeOk[r] = MaskV[1];
        2'd3:    sizeOk[r] = MaskV[2];
        default: sizeOk[r] = 1'b0;
      endcase
    end

    if (Bpi == 0) begin : g_flat
      assign rangeOk[r] = 1'b1;
    end else begin : g_indexed
      logic [OffW-1:0] relOff;
      logic [IntW-1:0] intId;
      assign relOff     = reqOffset - StartV;
      assign intId      = {relOff, 3'b000} >> bpiShift(Bpi);
      assign rangeOk[r] = (intId < NumIrqV);
    end

    assign legal[r] = sizeOk[r] && alignOk && rangeOk[r];
  end

  // Lowest index wins when entries overlap.
  always_comb begin
    matchIdx = '0;
    matchAny = 1'b0;
    for (int r = NumRegions - 1; r >= 0; r--) begin
      if (inReg[r]) begin
        matchIdx = IdxW'(r);
        matchAny = 1'b1;
      end
    end
  end

  assign selKind = regionKind_e'(RegionKind[int'(matchIdx)*2 +: 2]);
  assign accOk   = matchAny && legal[matchIdx];

  always_comb begin
    logic isRead;
    isRead       = reqValid && !reqWrite;
    strb.rdFwd   = isRead && accOk &&
                   (selKind == KIND_PLAIN || selKind == KIND_NOWRITE);
    strb.wrFwd   = reqValid && reqWrite && accOk && (selKind == KIND_PLAIN);
    strb.rdOnes  = isRead && accOk && (selKind == KIND_ONES);
    strb.rdZero  = isRead && !(strb.rdFwd || strb.rdOnes);
    strb.rspLoad = isRead;
    strb.size    = reqSize;
  end

  assign regHit = reqValid && accOk;
  assign regIdx = matchIdx;

  // R2
  no_halfword_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd1) |-> !regHit);

  // R4
  natural_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    regHit |-> ((int'(reqOffset) % (1 << reqSize)) == 0));

  // R8
  strobe_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdFwd || strb.wrFwd) |-> regHit);

  // R8
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdFwd && strb.wrFwd));

endmodule

// File: rtl/regdec_dpath.sv
module regdec_dpath
  import regdec_pkg::*;
#(
  parameter bit HostBigEndian = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t strb,
  input  logic [63:0] reqWData,
  input  logic [63:0] regRdData,
  output logic [63:0] regWData,
  output logic        rspValid,
  output logic [63:0] rspData
);

  logic [63:0] rspNext;

  assign regWData = laneOrder(reqWData, strb.size, HostBigEndian);

  always_comb begin
    if (strb.rdFwd)       rspNext = laneOrder(regRdData, strb.size, HostBigEndian);
    else if (strb.rdOnes) rspNext = sizeOnes(strb.size);
    else                  rspNext = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.rspLoad;
      rspData  <= strb.rspLoad ? rspNext : '0;
    end
  end

  // R7
  rsp_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdZero |=> (rspValid && rspData == 64'd0));

  // R11
  rsp_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdOnes |=> (rspData == sizeOnes($past(strb.size))));

  // R8
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rspLoad |=> rspValid);

  // R8
  rsp_only_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rspLoad |=> !rspValid);

endmodule

// File: rtl/regdec_top.sv
module regdec_top
  import regdec_pkg::*;
#(
  parameter int NumRegions = 6,
  parameter int OffW       = 12,
  parameter int NumPrivate = 32,
  parameter int NumShared  = 64,
  parameter bit HostBigEndian = 1'b1,
  parameter logic [NumRegions*OffW-1:0] RegionStart =
    {12'h210, 12'h200, 12'h100, 12'h080, 12'h010, 12'h000},
  parameter logic [NumRegions*OffW-1:0] RegionLen =
    {12'h010, 12'h010, 12'h100, 12'h080, 12'h010, 12'h010},
  parameter logic [NumRegions*3-1:0] RegionMask =
    {3'b010, 3'b010, 3'b011, 3'b110, 3'b010, 3'b010},
  parameter logic [NumRegions*4-1:0] RegionBpi =
    {4'd0, 4'd0, 4'd8, 4'd1, 4'd0, 4'd0},
  parameter logic [NumRegions*2-1:0] RegionKind =
    {2'd3, 2'd2, 2'd0, 2'd0, 2'd1, 2'd0},
  localparam int IdxW = (NumRegions > 1) ? $clog2(NumRegions) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic            reqWrite,
  input  logic [OffW-1:0] reqOffset,
  input  logic [1:0]      reqSize,
  input  logic [63:0]     reqWData,
  output logic [IdxW-1:0] regIdx,
  output logic            regHit,
  output logic            regRdStb,
  output logic            regWrStb,
  output logic [63:0]     regWData,
  input  logic [63:0]     regRdData,
  output logic            rspValid,
  output logic [63:0]     rspData
);

  ctlStrobes_t strb;

  regdec_ctrl #(
    .NumRegions (NumRegions),
    .OffW       (OffW),
    .NumPrivate (NumPrivate),
    .NumShared  (NumShared),
    .RegionStart(RegionStart),
    .RegionLen  (RegionLen),
    .RegionMask (RegionMask),
    .RegionBpi  (RegionBpi),
    .RegionKind (RegionKind)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqOffset(reqOffset),
    .reqSize  (reqSize),
    .regHit   (regHit),
    .regIdx   (regIdx),
    .strb     (strb)
  );

  regdec_dpath #(
    .HostBigEndian(HostBigEndian)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqWData (reqWData),
    .regRdData(regRdData),
    .regWData (regWData),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

  assign regRdStb = strb.rdFwd;
  assign regWrStb = strb.wrFwd;

endmodule

// File: tb/regdec_top_tb_top.sv
`timescale 1ns/1ps
module regdec_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqOffset = '0;
  logic [1:0]  reqSize = '0;
  logic [63:0] reqWData = '0;
  logic [2:0]  regIdx;
  logic        regHit, regRdStb, regWrStb, rspValid;
  logic [63:0] regWData, regRdData, rspData;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  // Expected response from the previous cycle.
  bit          prevRspV = 0;
  logic [63:0] prevRspD = '0;
  string       prevTag = "R8";

  // Behavioural region table.
  int stT[6] = '{'h000, 'h010, 'h080, 'h100, 'h200, 'h210};
  int lnT[6] = '{'h10, 'h10, 'h80, 'h100, 'h10, 'h10};
  int mkT[6] = '{2, 2, 6, 3, 2, 2};   // bit0 1B, bit1 4B, bit2 8B
  int bpT[6] = '{0, 0, 1, 8, 0, 0};
  int kdT[6] = '{0, 1, 0, 0, 2, 3};   // plain, zero, ones, no-write
  localparam int IrqCount = 96;

  always #2.5 clk = ~clk;

  function automatic logic [63:0] bankOf(input logic [11:0] off);
    return 64'hF0E1_D2C3_B4A5_9687 ^ {52'd0, off};
  endfunction

  assign regRdData = bankOf(reqOffset);

  regdec_top dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqOffset(reqOffset), .reqSize(reqSize), .reqWData(reqWData),
    .regIdx(regIdx), .regHit(regHit), .regRdStb(regRdStb),
    .regWrStb(regWrStb), .regWData(regWData), .regRdData(regRdData),
    .rspValid(rspValid), .rspData(rspData)
  );

  function automatic logic [63:0] bswap(input logic [63:0] d, input int nb);
    logic [63:0] o = '0;
    for (int i = 0; i < nb; i++) o[8*i +: 8] = d[8*(nb-1-i) +: 8];
    return o;
  endfunction

  function automatic logic [63:0] onesOf(input int nb);
    if (nb == 8) return '1;
    return (64'd1 << (8*nb)) - 64'd1;
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input bit w, input int off, input int sz,
                      input logic [63:0] wd);
    int nb, idx, rel, mbit;
    bit legal, eRd, eWr, eRspV;
    logic [63:0] eRspD;
    string tag, rtag;
    @(negedge clk);
    reqValid = v; reqWrite = w; reqOffset = 12'(off);
    reqSize = 2'(sz); reqWData = wd;
    #1;
    nb = 1 << sz;
    idx = -1;
    for (int r = 5; r >= 0; r--)
      if (off >= stT[r] && off < stT[r] + lnT[r]) idx = r;
    legal = 0;
    if (idx < 0) tag = "R1";
    else begin
      mbit = (sz == 0) ? 1 : (sz == 2) ? 2 : (sz == 3) ? 4 : 0;
      rel = off - stT[idx];
      if (sz == 1) tag = "R2";
      else if ((mkT[idx] & mbit) == 0) tag = "R3";
      else if (off % nb != 0) tag = "R4";
      else if (bpT[idx] != 0 && rel * 8 / bpT[idx] >= IrqCount) tag = "R5";
      else begin
        legal = 1;
        case (kdT[idx])
          1: tag = "R10";
          2: tag = "R11";
          3: tag = "R12";
          default: tag = (bpT[idx] == 0) ? "R6" : "R8";
        endcase
      end
    end
    eRd = v && !w && legal && (kdT[idx] == 0 || kdT[idx] == 3);
    eWr = v && w && legal && kdT[idx] == 0;
    eRspV = v && !w;
    if (eRd) eRspD = bswap(bankOf(12'(off)), nb);
    else if (eRspV && legal && kdT[idx] == 2) eRspD = onesOf(nb);
    else eRspD = '0;
    rtag = !legal ? "R7" : (eRd ? "R9" : tag);

    // Response of the previous request, same cycle as this decode.
    chk("R8", "rspValid", 64'(rspValid), 64'(prevRspV));
    chk(prevTag, "rspData", rspData, prevRspD);
    chk(tag, "regHit", 64'(regHit), 64'(v && legal));
    if (v && legal) chk("R1", "regIdx", 64'(regIdx), 64'(idx));
    chk(tag, "regRdStb", 64'(regRdStb), 64'(eRd));
    chk(tag, "regWrStb", 64'(regWrStb), 64'(eWr));
    if (eWr) chk("R9", "regWData", regWData, bswap(wd, nb));
    prevRspV = eRspV; prevRspD = eRspD; prevTag = rtag;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R8", "reset rspValid", 64'(rspValid), 64'd0);
    chk("R8", "reset rspData", rspData, 64'd0);

    step(1, 0, 'h000, 2, 0);                    // R6 plain control region
    step(1, 0, 'h00C, 2, 0);
    step(1, 0, 'h00E, 2, 0);                    // R4 misaligned
    step(1, 0, 'h002, 1, 0);                    // R2 halfword
    step(1, 0, 'h000, 0, 0);                    // R3 size not allowed
    step(1, 0, 'h020, 2, 0);                    // R1 gap
    step(1, 0, 'h010, 2, 0);                    // R10 zero kind
    step(1, 1, 'h014, 2, 64'h1111_2222_3333_4444);
    step(1, 0, 'h200, 2, 0);                    // R11 ones kind
    step(1, 0, 'h208, 2, 0);
    step(1, 1, 'h204, 2, 64'h55);
    step(1, 1, 'h210, 2, 64'h66);               // R12 no-write
    step(1, 0, 'h210, 2, 0);
    step(1, 0, 'h088, 2, 0);                    // R5 intid 64 ok
    step(1, 0, 'h08C, 2, 0);                    // R5 intid 96 rejected
    step(1, 0, 'h088, 3, 0);
    step(1, 0, 'h08C, 3, 0);                    // R4 and R5 together
    step(1, 0, 'h15F, 0, 0);                    // intid 95
    step(1, 0, 'h160, 0, 0);                    // intid 96
    step(1, 0, 'h15C, 2, 0);
    step(1, 1, 'h104, 2, 64'hAABB_CCDD_1122_3344); // R9 byte order
    step(1, 1, 'h080, 3, 64'h0102_0304_0506_0708);
    step(1, 1, 'h08C, 2, 64'h77);               // R7 dropped write
    step(1, 0, 'h2FF, 0, 0);                    // R1 beyond table
    step(0, 0, 'h000, 2, 0);
    step(1, 0, 'h000, 2, 0);

    for (int n = 0; n < 3000; n++)
      step($urandom_range(0, 7) != 0, $urandom_range(0, 1) == 1,
           $urandom_range(0, 'h2FF), $urandom_range(0, 3),
           {$urandom, $urandom});
    step(0, 0, 0, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule